// File: doc/BRIEF.md
# Indexed Host Register Port

This block is the slave side of an asynchronous, memory-style parallel bus that an external processor uses to reach the registers and data stream of an engine. The data path is 8 or 16 bits wide, set by a parameter. A chip select, a 3-bit word address and active-low read and write strobes are brought into the engine clock domain. Registers are not mapped flat into the host address space. The host loads a pointer through one address and then moves data through a second address. Every completed data access advances the pointer, so a block of registers can be streamed without reloading the pointer.

With a 16-bit path, each data access moves one full internal word. With an 8-bit path, a word is moved as two bytes, low byte first. The word access completes on the high byte. A second chip select has no effect on the register port. When bypass is enabled, that select is routed to the display select output, so that host cycles reach the panel directly.

Top module: `idx_host_port`

## Requirements
- R1: After reset the pointer is 0, `host_doe` is low, `reg_we` and `reg_re` are low, and an 8-bit port expects a low byte next.
- R2: `host_doe` is high only while `host_cs1_n` and `host_rd_n` are both low. While a read strobe is low at address 0, `host_dout` shows the pointer, zero-extended.
- R3: A host write to address 1 raises `reg_we` for exactly one cycle after the synchronised rising edge of the write strobe. At that point `reg_idx` is the pointer and `reg_wdata` is the data held on the bus while the strobe was low.
- R4: Each completed data-port word access, read or write, advances the pointer by one. The pointer wraps from 2^IDX_W-1 to 0.
- R5: A host write to address 0 loads the pointer from the low IDX_W data bits and resets the 8-bit byte phase to low byte. The pointer changes only on a completed access.
- R6: A read strobe at address 1 presents the word at the pointer on `host_dout` no later than 2 clocks after the strobe falls. Once the strobe rises, a single `reg_re` pulse follows.
- R7: In 8-bit mode, the first data-port access of a word carries bits 7:0 and the second carries bits 15:8. A write issues `reg_we` only on the second byte, with `{second, first}`. On a read, the high byte returns the value captured when the low byte was read.
- R8: A read at any of addresses 2 to 7 returns zero, and a write there changes neither the pointer nor the byte phase.
- R9: `panel_cs_n` follows `host_cs2_n` while `bypass_en` is high and is held high otherwise.
- R10: Strobes that occur while `host_cs1_n` is high cause no register access, whatever `host_cs2_n` is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs1_n | input | 1 | Register port select, active low |
| host_cs2_n | input | 1 | Secondary select, routed to the panel in bypass |
| host_addr | input | 3 | Host word address |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_din | input | BUS_W | Data driven by the host |
| host_dout | output | BUS_W | Data returned to the host |
| host_doe | output | 1 | Output enable for the data pads |
| bypass_en | input | 1 | Routes the secondary select to the panel |
| panel_cs_n | output | 1 | Display select, active low |
| reg_idx | output | IDX_W | Current pointer into the register space |
| reg_wdata | output | REG_W | Word to be written |
| reg_we | output | 1 | One-cycle write command |
| reg_re | output | 1 | One-cycle read-consumed pulse |
| reg_rdata | input | REG_W | Word at `reg_idx`, combinational from the register file |

## Verification
The hardest case to reach from the ports is a high byte that is read in 8-bit mode after the register file has changed its word since the low byte was read. The bench's register model mixes a salt value into the upper half. The bench changes the salt between the two byte reads, so only a captured copy can return the expected byte. A second difficult case is the byte phase left half-finished by a lone low-byte write. The stimulus then reloads the pointer and checks that the next pair of bytes forms a fresh word. Wrap-around is reached by loading the top pointer value directly.

// File: rtl/hb_pkg.sv
package hb_pkg;
   typedef enum logic [1:0] {
      KIND_INDEX = 2'd0,
      KIND_DATA  = 2'd1,
      KIND_NONE  = 2'd2
   } port_kind_t;

   localparam logic [2:0] ADDR_INDEX = 3'd0;
   localparam logic [2:0] ADDR_DATA  = 3'd1;

   function automatic port_kind_t decode_addr(input logic [2:0] a);
      if (a == ADDR_INDEX)     return KIND_INDEX;
      else if (a == ADDR_DATA) return KIND_DATA;
      else                     return KIND_NONE;
   endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hb_sync needs at least two stages");
   end

   logic [W-1:0] st [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= RST_VAL;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[g] <= RST_VAL;
            else        st[g] <= st[g-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/hb_strobe.sv
module hb_strobe #(
   parameter int BUS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_s_n,
   input  logic             rd_s_n,
   input  logic             wr_s_n,
   input  logic [2:0]       host_addr,
   input  logic [BUS_W-1:0] host_din,
   output logic             wr_done,
   output logic             rd_done,
   output logic [2:0]       acc_addr,
   output logic [BUS_W-1:0] acc_wdata
);
   logic wr_prev, rd_prev;
   logic wr_armed, rd_armed;
   logic wr_edge, rd_edge;
   logic wr_low_sel, rd_low_sel;

   assign wr_low_sel = !cs_s_n && !wr_s_n;
   assign rd_low_sel = !cs_s_n && !rd_s_n;
   assign wr_edge    = wr_armed && wr_s_n && !wr_prev;
   assign rd_edge    = rd_armed && rd_s_n && !rd_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev   <= 1'b1;
         rd_prev   <= 1'b1;
         wr_armed  <= 1'b0;
         rd_armed  <= 1'b0;
         wr_done   <= 1'b0;
         rd_done   <= 1'b0;
         acc_addr  <= '0;
         acc_wdata <= '0;
      end else begin
         wr_prev <= wr_s_n;
         rd_prev <= rd_s_n;
         wr_done <= wr_edge;
         rd_done <= rd_edge;
         if (wr_low_sel) begin
            wr_armed  <= 1'b1;
            acc_addr  <= host_addr;
            acc_wdata <= host_din;
         end else if (wr_edge) begin
            wr_armed <= 1'b0;
         end
         if (rd_low_sel) begin
            rd_armed <= 1'b1;
            acc_addr <= host_addr;
         end else if (rd_edge) begin
            rd_armed <= 1'b0;
         end
      end
   end

   AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_done && rd_done)); // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done); // R3
endmodule

// File: rtl/hb_regport.sv
module hb_regport
   import hb_pkg::*;
#(
   parameter int BUS_W = 16,
   parameter int IDX_W = 8,
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_done,
   input  logic             rd_done,
   input  logic [2:0]       acc_addr,
   input  logic [BUS_W-1:0] acc_wdata,
   input  logic [2:0]       look_addr,
   input  logic [REG_W-1:0] reg_rdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic [IDX_W-1:0] reg_idx,
   output logic [REG_W-1:0] reg_wdata,
   output logic             reg_we,
   output logic             reg_re
);
   port_kind_t       acc_kind, look_kind;
   logic [IDX_W-1:0] idx_q;
   logic             idx_load;
   logic [BUS_W-1:0] data_view;

   assign acc_kind  = decode_addr(acc_addr);
   assign look_kind = decode_addr(look_addr);
   assign idx_load  = wr_done && (acc_kind == KIND_INDEX);
   assign reg_idx   = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               idx_q <= '0;
      else if (idx_load)        idx_q <= acc_wdata[IDX_W-1:0];
      else if (reg_we || reg_re) idx_q <= idx_q + 1'b1;
   end

   always_comb begin
      case (look_kind)
         KIND_INDEX: bus_rdata = BUS_W'(idx_q);
         KIND_DATA:  bus_rdata = data_view;
         default:    bus_rdata = '0;
      endcase
   end

   if (BUS_W == REG_W) begin : g_wide
      assign reg_we    = wr_done && (acc_kind == KIND_DATA);
      assign reg_re    = rd_done && (acc_kind == KIND_DATA);
      assign reg_wdata = acc_wdata;
      assign data_view = reg_rdata;
   end else begin : g_narrow
      logic             half_q;
      logic [BUS_W-1:0] lo_q, hi_q;
      logic             wr_beat, rd_beat;

      assign wr_beat = wr_done && (acc_kind == KIND_DATA);
      assign rd_beat = rd_done && (acc_kind == KIND_DATA);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            half_q <= 1'b0;
            lo_q   <= '0;
            hi_q   <= '0;
         end else if (idx_load) begin
            half_q <= 1'b0;
         end else if (wr_beat) begin
            if (!half_q) lo_q <= acc_wdata;
            half_q <= !half_q;
         end else if (rd_beat) begin
            if (!half_q) hi_q <= reg_rdata[REG_W-1:BUS_W];
            half_q <= !half_q;
         end
      end

      assign reg_we    = wr_beat && half_q;
      assign reg_re    = rd_beat && half_q;
      assign reg_wdata = {acc_wdata, lo_q};
      assign data_view = half_q ? hi_q : reg_rdata[BUS_W-1:0];
   end

   AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we); // R3
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we || reg_re) |=> reg_idx == IDX_W'($past(reg_idx) + 1'b1)); // R4
   AST_IDX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_done || rd_done) |=> reg_idx == $past(reg_idx)); // R5
   AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re)); // R6
endmodule

// File: rtl/idx_host_port.sv
module idx_host_port #(
   parameter int BUS_W = 16,
   parameter int IDX_W = 8,
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_cs1_n,
   input  logic             host_cs2_n,
   input  logic [2:0]       host_addr,
   input  logic             host_rd_n,
   input  logic             host_wr_n,
   input  logic [BUS_W-1:0] host_din,
   output logic [BUS_W-1:0] host_dout,
   output logic             host_doe,
   input  logic             bypass_en,
   output logic             panel_cs_n,
   output logic [IDX_W-1:0] reg_idx,
   output logic [REG_W-1:0] reg_wdata,
   output logic             reg_we,
   output logic             reg_re,
   input  logic [REG_W-1:0] reg_rdata
);
   localparam int BEATS     = REG_W / BUS_W;
   localparam int SYNC_DEPTH = 2;

   if (!(BUS_W == 8 || BUS_W == 16)) begin : g_bad_bus
      $error("BUS_W must be 8 or 16");
   end
   if (BEATS * BUS_W != REG_W || BEATS < 1 || BEATS > 2) begin : g_bad_reg
      $error("REG_W must be BUS_W or twice BUS_W");
   end
   if (IDX_W < 1 || IDX_W > BUS_W) begin : g_bad_idx
      $error("IDX_W must lie in 1..BUS_W");
   end

   logic [2:0]       strobes_s;
   logic             wr_done, rd_done;
   logic [2:0]       acc_addr;
   logic [BUS_W-1:0] acc_wdata;
   logic [BUS_W-1:0] bus_rdata;

   hb_sync #(.W(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b111)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({host_cs1_n, host_rd_n, host_wr_n}),
      .q     (strobes_s)
   );

   hb_strobe #(.BUS_W(BUS_W)) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_s_n    (strobes_s[2]),
      .rd_s_n    (strobes_s[1]),
      .wr_s_n    (strobes_s[0]),
      .host_addr (host_addr),
      .host_din  (host_din),
      .wr_done   (wr_done),
      .rd_done   (rd_done),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata)
   );

   hb_regport #(.BUS_W(BUS_W), .IDX_W(IDX_W), .REG_W(REG_W)) u_regport (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_done   (wr_done),
      .rd_done   (rd_done),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .look_addr (host_addr),
      .reg_rdata (reg_rdata),
      .bus_rdata (bus_rdata),
      .reg_idx   (reg_idx),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_re    (reg_re)
   );

   assign host_doe   = !host_cs1_n && !host_rd_n;
   assign host_dout  = host_doe ? bus_rdata : '0;
   assign panel_cs_n = bypass_en ? host_cs2_n : 1'b1;

   AST_NO_STRAY_WE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $past(strobes_s[0])); // R3
endmodule

// File: tb/idx_host_port_tb.sv
module idx_host_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_a_n = 1'b1, cs_b_n = 1'b1, cs2_n = 1'b1;
   logic [2:0]  addr = '0;
   logic        rd_n = 1'b1, wr_n = 1'b1;
   logic [15:0] din = '0;
   logic        bypass = 1'b0;
   logic [7:0]  salt = '0;

   logic [15:0] dout16;  logic [7:0] dout8;
   logic        doe16, doe8, pcs16, pcs8;
   logic [7:0]  idx16, idx8;
   logic [15:0] wd16, wd8, rd16, rd8;
   logic        we16, we8, re16, re8;

   int checks = 0;
   int fails  = 0;
   logic [23:0] q16[$];
   logic [23:0] q8[$];

   always #10 clk = ~clk;

   assign rd16 = {~idx16, idx16};
   assign rd8  = {idx8 ^ salt, ~idx8};

   idx_host_port #(.BUS_W(16), .IDX_W(8), .REG_W(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .host_cs1_n(cs_a_n), .host_cs2_n(cs2_n),
      .host_addr(addr), .host_rd_n(rd_n), .host_wr_n(wr_n), .host_din(din),
      .host_dout(dout16), .host_doe(doe16), .bypass_en(bypass), .panel_cs_n(pcs16),
      .reg_idx(idx16), .reg_wdata(wd16), .reg_we(we16), .reg_re(re16), .reg_rdata(rd16));

   idx_host_port #(.BUS_W(8), .IDX_W(8), .REG_W(16)) u_dut8 (
      .clk(clk), .rst_n(rst_n), .host_cs1_n(cs_b_n), .host_cs2_n(cs2_n),
      .host_addr(addr), .host_rd_n(rd_n), .host_wr_n(wr_n), .host_din(din[7:0]),
      .host_dout(dout8), .host_doe(doe8), .bypass_en(bypass), .panel_cs_n(pcs8),
      .reg_idx(idx8), .reg_wdata(wd8), .reg_we(we8), .reg_re(re8), .reg_rdata(rd8));

   task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic sel_low(input int who);
      if (who == 0) cs_a_n = 1'b0;
      else if (who == 1) cs_b_n = 1'b0;
   endtask

   task automatic sel_high();
      cs_a_n = 1'b1; cs_b_n = 1'b1;
   endtask

   // who: 0 = 16-bit port, 1 = 8-bit port, 2 = neither selected
   task automatic bus_write(input int who, input logic [2:0] a, input logic [15:0] d);
      @(negedge clk); addr = a; din = d; sel_low(who);
      @(negedge clk); wr_n = 1'b0;
      repeat (5) @(negedge clk);
      wr_n = 1'b1;
      repeat (5) @(negedge clk);
      sel_high();
      repeat (2) @(negedge clk);
   endtask

   task automatic bus_read(input int who, input logic [2:0] a,
                           output logic [15:0] v, output logic oe);
      @(negedge clk); addr = a; sel_low(who); rd_n = 1'b0;
      repeat (2) @(negedge clk);
      v  = (who == 1) ? {8'h00, dout8} : dout16;
      oe = (who == 1) ? doe8 : doe16;
      rd_n = 1'b1;
      repeat (5) @(negedge clk);
      sel_high();
      repeat (2) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && we16) begin
         if (q16.size() == 0) check("R3 unexpected wide write", {idx16, wd16}, 24'h0);
         else check("R3 wide write", {idx16, wd16}, q16.pop_front());
      end
      if (rst_n && we8) begin
         if (q8.size() == 0) check("R7 unexpected narrow write", {idx8, wd8}, 24'h0);
         else check("R7 narrow write", {idx8, wd8}, q8.pop_front());
      end
   end

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=expired expected=done");
      summary();
   end

   initial begin
      logic [15:0] v;
      logic        oe;
      repeat (3) @(negedge clk);
      check("R1 doe after reset", {23'h0, doe16}, 24'h0);
      check("R1 we/re after reset", {20'h0, we16, re16, we8, re8}, 24'h0);
      check("R1 pointer after reset", {16'h0, idx16}, 24'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      bus_read(0, 3'd0, v, oe);
      check("R1 index read wide", {8'h0, v}, 24'h0);
      check("R2 doe during read", {23'h0, oe}, 24'h1);
      check("R2 doe idle", {23'h0, doe16}, 24'h0);

      // R5 load pointer
      bus_write(0, 3'd0, 16'h0010);
      bus_read(0, 3'd0, v, oe);
      check("R5 pointer load", {8'h0, v}, 24'h000010);

      // R3 / R4 data write
      q16.push_back({8'h10, 16'hA5C3});
      bus_write(0, 3'd1, 16'hA5C3);
      bus_read(0, 3'd0, v, oe);
      check("R4 pointer after write", {8'h0, v}, 24'h000011);

      // R6 data read
      bus_read(0, 3'd1, v, oe);
      check("R6 data read value", {8'h0, v}, 24'h00EE11);
      bus_read(0, 3'd0, v, oe);
      check("R4 pointer after read", {8'h0, v}, 24'h000012);

      // burst of writes
      bus_write(0, 3'd0, 16'h0040);
      for (int i = 0; i < 4; i++) begin
         q16.push_back({8'(8'h40 + i), 16'(16'h1000 * (i + 1) + i)});
         bus_write(0, 3'd1, 16'(16'h1000 * (i + 1) + i));
      end
      for (int i = 0; i < 3; i++) begin
         bus_read(0, 3'd1, v, oe);
         check("R6 burst read", {8'h0, v}, {8'h0, ~8'(8'h44 + i), 8'(8'h44 + i)});
      end

      // R4 wrap
      bus_write(0, 3'd0, 16'h00FF);
      q16.push_back({8'hFF, 16'h1234});
      bus_write(0, 3'd1, 16'h1234);
      bus_read(0, 3'd0, v, oe);
      check("R4 pointer wrap", {8'h0, v}, 24'h0);

      // R8 spare addresses
      bus_write(0, 3'd5, 16'h7777);
      bus_read(0, 3'd0, v, oe);
      check("R8 spare write ignored", {8'h0, v}, 24'h0);
      bus_read(0, 3'd3, v, oe);
      check("R8 spare read zero", {8'h0, v}, 24'h0);

      // R10 strobes without select
      bus_write(2, 3'd0, 16'h0055);
      bus_write(2, 3'd1, 16'h0066);
      bus_read(0, 3'd0, v, oe);
      check("R10 unselected write ignored", {8'h0, v}, 24'h0);

      // R9 bypass routing
      @(negedge clk); cs2_n = 1'b0; bypass = 1'b0;
      @(negedge clk);
      check("R9 held high without bypass", {22'h0, pcs16, pcs8}, 24'h3);
      bypass = 1'b1;
      @(negedge clk);
      check("R9 follows select in bypass", {22'h0, pcs16, pcs8}, 24'h0);
      bus_write(2, 3'd0, 16'h0077);
      bus_read(0, 3'd0, v, oe);
      check("R10 bypass cycle no access", {8'h0, v}, 24'h0);
      cs2_n = 1'b1;
      @(negedge clk);
      check("R9 released in bypass", {22'h0, pcs16, pcs8}, 24'h3);
      bypass = 1'b0;

      // R7 narrow write
      bus_read(1, 3'd0, v, oe);
      check("R1 narrow pointer", {8'h0, v}, 24'h0);
      bus_write(1, 3'd0, 16'h0020);
      q8.push_back({8'h20, 16'h5A3C});
      bus_write(1, 3'd1, 16'h003C);
      bus_read(1, 3'd0, v, oe);
      check("R7 pointer held after low byte", {8'h0, v}, 24'h000020);
      bus_write(1, 3'd1, 16'h005A);
      bus_read(1, 3'd0, v, oe);
      check("R7 pointer after high byte", {8'h0, v}, 24'h000021);

      // R7 narrow read with snapshot
      salt = 8'h00;
      bus_read(1, 3'd1, v, oe);
      check("R7 low byte read", {8'h0, v}, 24'h0000DE);
      salt = 8'hFF;
      bus_read(1, 3'd1, v, oe);
      check("R7 high byte snapshot", {8'h0, v}, 24'h000021);
      bus_read(1, 3'd0, v, oe);
      check("R4 narrow pointer after read", {8'h0, v}, 24'h000022);

      // R5 pointer write resets byte phase
      bus_write(1, 3'd1, 16'h0011);
      bus_write(1, 3'd0, 16'h0030);
      q8.push_back({8'h30, 16'h3322});
      bus_write(1, 3'd1, 16'h0022);
      bus_write(1, 3'd1, 16'h0033);
      bus_read(1, 3'd0, v, oe);
      check("R5 phase reset pointer", {8'h0, v}, 24'h000031);

      check("R3 scoreboard drained wide", 24'(q16.size()), 24'h0);
      check("R7 scoreboard drained narrow", 24'(q8.size()), 24'h0);
      summary();
   end
endmodule